// File: doc/BRIEF.md
# Test-Mode Counter Preload Gate

This block sits on the register write path of a multi-channel correlator. Test software uses it to force a known starting value into two counters in each channel: the 11-bit code-phase counter and the 18-bit carrier-cycle counter. A write to one of these preload locations produces a one-cycle load strobe and a load value on the counter's interface.

The write is honoured only when two conditions hold for that channel. The channel's test-mode flag must be set, and the most significant bit of the matching phase accumulator must be low. The code-phase preload checks the code phase MSB. The carrier-cycle preload checks the carrier phase MSB. In every other case the write is dropped silently.

Each channel has its own pair of addresses. Two broadcast addresses reach every channel at once, but only the channels that are in test mode respond. The carrier preload carries 16 bits. These land in the upper part of the 18-bit counter, and the two lowest bits are cleared.

Top module: `tmode_preload_gate`

## Requirements
- R1: A code-phase preload write produces `code_ld` for a channel only when that channel's `test_mode` bit is 1 and its `code_msb` bit is 0. Otherwise that channel's strobe stays 0 and its load value is unchanged.
- R2: A carrier-cycle preload write produces `carr_ld` for a channel only when that channel's `test_mode` bit is 1 and its `carr_msb` bit is 0. Otherwise that channel's strobe stays 0 and its load value is unchanged.
- R3: An accepted code-phase load value equals `wr_data[10:0]`. Bits 15..11 of `wr_data` have no effect on it.
- R4: An accepted carrier-cycle load value equals `{wr_data[15:0], 2'b00}`. Bits 1..0 are always zero.
- R5: Channel n (n = 0..5) decodes its code-phase preload at address 0x06 + 0x10·n and its carrier-cycle preload at 0x07 + 0x10·n. Each per-channel address affects that channel only.
- R6: Address 0x76 is the broadcast code-phase preload and address 0x77 is the broadcast carrier-cycle preload. A broadcast write loads every channel that meets R1 or R2 respectively. Channels whose `test_mode` bit is 0 are left unchanged.
- R7: A load strobe rises in the cycle after the clock edge that samples the accepted `wr_en`. It lasts one cycle for each write cycle. With `wr_en` low, every strobe is 0.
- R8: A write to any other address produces no strobe and leaves every load value unchanged. This includes the offsets 6 and 7 of the unused channel slot 0x6_.
- R9: After reset, all strobes and all load values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| test_mode | input | 6 | Per-channel test-mode flag |
| code_msb | input | 6 | Per-channel code phase accumulator MSB |
| carr_msb | input | 6 | Per-channel carrier phase accumulator MSB |
| code_ld | output | 6 | Per-channel code-phase counter load strobe |
| code_ld_val | output | 66 | Code-phase load values, channel n in bits 11n+10..11n |
| carr_ld | output | 6 | Per-channel carrier-cycle counter load strobe |
| carr_ld_val | output | 108 | Carrier-cycle load values, channel n in bits 18n+17..18n |

## Verification
All results pass through one register stage. A write presented at a clock edge shows its strobes and load values from that edge until the next one. The bench changes inputs on the falling edge. It samples every strobe and value on the following falling edge, one cycle after the write. It then drops `wr_en` and samples again one cycle later, to confirm that the strobes have returned to zero and that the values hold. A reference model in the bench tracks the expected load value for each channel and updates it only for writes it judges accepted. Dropped writes, broadcasts and unknown addresses are therefore caught through values that should not have moved.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    // Kind of preload target decoded from one write
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CODE = 2'd1,
        TGT_CARR = 2'd2
    } tgt_e;

endpackage

// File: rtl/tpg_decode.sv
module tpg_decode
    import tpg_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int ADDR_W    = 8,
    parameter int SLOT_W    = 4,
    parameter int CODE_OFS  = 6,
    parameter int CARR_OFS  = 7,
    parameter int BCAST_IDX = 7
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output tgt_e              tgt,
    output logic [NUM_CH-1:0] ch_sel
);
    localparam int IDX_W = ADDR_W - SLOT_W;

    logic [SLOT_W-1:0] slot_ofs;
    logic [IDX_W-1:0]  slot_idx;

    assign slot_ofs = wr_addr[SLOT_W-1:0];
    assign slot_idx = wr_addr[ADDR_W-1:SLOT_W];

    always_comb begin
        tgt    = TGT_NONE;
        ch_sel = '0;
        if (wr_en) begin
            if (slot_ofs == SLOT_W'(CODE_OFS)) begin
                tgt = TGT_CODE;
            end else if (slot_ofs == SLOT_W'(CARR_OFS)) begin
                tgt = TGT_CARR;
            end
            for (int n = 0; n < NUM_CH; n++) begin
                ch_sel[n] = (slot_idx == IDX_W'(n)) ||
                            (slot_idx == IDX_W'(BCAST_IDX));
            end
            if (tgt == TGT_NONE) begin
                ch_sel = '0;
            end
        end
    end

endmodule

// File: rtl/tpg_chan_gate.sv
module tpg_chan_gate
    import tpg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CODE_W = 11,
    parameter int CARR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tgt_e              tgt,
    input  logic              sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              test_mode,
    input  logic              code_msb,
    input  logic              carr_msb,
    output logic              code_ld,
    output logic [CODE_W-1:0] code_val,
    output logic              carr_ld,
    output logic [CARR_W-1:0] carr_val
);
    localparam int CARR_PAD = CARR_W - DATA_W;

    typedef struct packed {
        logic              code_ld;
        logic [CODE_W-1:0] code_val;
        logic              carr_ld;
        logic [CARR_W-1:0] carr_val;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.code_ld = 1'b0;
        st_d.carr_ld = 1'b0;
        if (sel && test_mode) begin
            if (tgt == TGT_CODE && !code_msb) begin
                st_d.code_ld  = 1'b1;
                st_d.code_val = wr_data[CODE_W-1:0];
            end
            if (tgt == TGT_CARR && !carr_msb) begin
                st_d.carr_ld  = 1'b1;
                st_d.carr_val = {wr_data, {CARR_PAD{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_ld  = st_q.code_ld;
    assign code_val = st_q.code_val;
    assign carr_ld  = st_q.carr_ld;
    assign carr_val = st_q.carr_val;

    // R1: a code strobe needs test mode and a low code MSB in the write cycle
    a_r1_code_gate: assert property (@(posedge clk) disable iff (!rst_n)
        code_ld |-> $past(test_mode && !code_msb && sel));

    // R2: a carrier strobe needs test mode and a low carrier MSB
    a_r2_carr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        carr_ld |-> $past(test_mode && !carr_msb && sel));

    // R3: code load value is the low data bits of the write
    a_r3_code_value: assert property (@(posedge clk) disable iff (!rst_n)
        code_ld |-> code_val == $past(wr_data[CODE_W-1:0]));

    // R4: carrier load value is the data shifted up with zeroed low bits
    a_r4_carr_value: assert property (@(posedge clk) disable iff (!rst_n)
        carr_ld |-> carr_val == {$past(wr_data), {CARR_PAD{1'b0}}});

    // R8: with no strobe, load values hold
    a_r8_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ld && !carr_ld |-> $stable(code_val) && $stable(carr_val));

endmodule

// File: rtl/tmode_preload_gate.sv
module tmode_preload_gate
    import tpg_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int CODE_W    = 11,
    parameter int CARR_W    = 18,
    parameter int SLOT_W    = 4,
    parameter int CODE_OFS  = 6,
    parameter int CARR_OFS  = 7,
    parameter int BCAST_IDX = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]        test_mode,
    input  logic [NUM_CH-1:0]        code_msb,
    input  logic [NUM_CH-1:0]        carr_msb,
    output logic [NUM_CH-1:0]        code_ld,
    output logic [NUM_CH*CODE_W-1:0] code_ld_val,
    output logic [NUM_CH-1:0]        carr_ld,
    output logic [NUM_CH*CARR_W-1:0] carr_ld_val
);
    tgt_e              tgt;
    logic [NUM_CH-1:0] ch_sel;

    tpg_decode #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .SLOT_W   (SLOT_W),
        .CODE_OFS (CODE_OFS),
        .CARR_OFS (CARR_OFS),
        .BCAST_IDX(BCAST_IDX)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .tgt    (tgt),
        .ch_sel (ch_sel)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        tpg_chan_gate #(
            .DATA_W(DATA_W),
            .CODE_W(CODE_W),
            .CARR_W(CARR_W)
        ) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .tgt      (tgt),
            .sel      (ch_sel[n]),
            .wr_data  (wr_data),
            .test_mode(test_mode[n]),
            .code_msb (code_msb[n]),
            .carr_msb (carr_msb[n]),
            .code_ld  (code_ld[n]),
            .code_val (code_ld_val[n*CODE_W +: CODE_W]),
            .carr_ld  (carr_ld[n]),
            .carr_val (carr_ld_val[n*CARR_W +: CARR_W])
        );
    end

    // R8: a code strobe only follows a write at a code preload offset
    a_r8_code_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (|code_ld) |-> $past(wr_en && wr_addr[SLOT_W-1:0] == SLOT_W'(CODE_OFS)));

    // R8: a carrier strobe only follows a write at a carrier preload offset
    a_r8_carr_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (|carr_ld) |-> $past(wr_en && wr_addr[SLOT_W-1:0] == SLOT_W'(CARR_OFS)));

    // R7: a write targets one counter kind, so both strobe kinds never coexist
    a_r7_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !((|code_ld) && (|carr_ld)));

    // R7: no write strobe, no load strobe in the next cycle
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (code_ld == '0) && (carr_ld == '0));

endmodule

// File: tb/tb_tmode_preload_gate.sv
module tb_tmode_preload_gate;
    localparam int NCH = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic [NCH-1:0]    test_mode = '0;
    logic [NCH-1:0]    code_msb = '0;
    logic [NCH-1:0]    carr_msb = '0;
    logic [NCH-1:0]    code_ld;
    logic [NCH*11-1:0] code_ld_val;
    logic [NCH-1:0]    carr_ld;
    logic [NCH*18-1:0] carr_ld_val;

    int checks = 0;
    int errors = 0;
    logic [10:0] m_code [NCH];
    logic [17:0] m_carr [NCH];

    always #5 clk = ~clk;

    tmode_preload_gate dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .test_mode(test_mode), .code_msb(code_msb),
        .carr_msb(carr_msb), .code_ld(code_ld), .code_ld_val(code_ld_val),
        .carr_ld(carr_ld), .carr_ld_val(carr_ld_val)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit hits(input logic [7:0] a, input int ch, input int ofs);
        return (a[3:0] == 4'(ofs)) && (a[7:4] == 4'(ch) || a[7:4] == 4'd7);
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        if (a[3:0] != 4'd6 && a[3:0] != 4'd7) return "R8";
        if (a[7:4] == 4'd7) return "R6";
        if (a[7:4] < 4'(NCH)) return "R5";
        return "R8";
    endfunction

    task automatic check_values(input string tc, input string tk);
        for (int c = 0; c < NCH; c++) begin
            check(tc, $sformatf("code_val ch%0d", c), 32'(code_ld_val[c*11 +: 11]), 32'(m_code[c]));
            check(tk, $sformatf("carr_val ch%0d", c), 32'(carr_ld_val[c*18 +: 18]), 32'(m_carr[c]));
            check("R4", $sformatf("carr_val low bits ch%0d", c), 32'(carr_ld_val[c*18 +: 2]), 32'd0);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d,
                            input logic [NCH-1:0] tm, input logic [NCH-1:0] cm,
                            input logic [NCH-1:0] km);
        logic [NCH-1:0] e_code, e_carr;
        string t;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        test_mode = tm; code_msb = cm; carr_msb = km;
        for (int c = 0; c < NCH; c++) begin
            e_code[c] = hits(a, c, 6) && tm[c] && !cm[c];
            e_carr[c] = hits(a, c, 7) && tm[c] && !km[c];
            if (e_code[c]) m_code[c] = d[10:0];
            if (e_carr[c]) m_carr[c] = {d, 2'b00};
        end
        t = tag_for(a);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            check((hits(a, c, 6) && t != "R8") ? "R1" : t,
                  $sformatf("code_ld ch%0d addr %0h", c, a), 32'(code_ld[c]), 32'(e_code[c]));
            check((hits(a, c, 7) && t != "R8") ? "R2" : t,
                  $sformatf("carr_ld ch%0d addr %0h", c, a), 32'(carr_ld[c]), 32'(e_carr[c]));
        end
        check_values("R3", "R4");
        wr_en = 1'b0;
        @(negedge clk);
        check("R7", "code_ld after idle", 32'(code_ld), 32'd0);
        check("R7", "carr_ld after idle", 32'(carr_ld), 32'd0);
        check_values("R8", "R8");
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a;
        void'($urandom(32'd20250611));
        for (int c = 0; c < NCH; c++) begin
            m_code[c] = '0;
            m_carr[c] = '0;
        end
        repeat (3) @(negedge clk);
        check("R9", "code_ld at reset", 32'(code_ld), 32'd0);
        check("R9", "carr_ld at reset", 32'(carr_ld), 32'd0);
        check_values("R9", "R9");
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        do_write(8'h06, 16'h0123, 6'b000000, 6'b0, 6'b0);  // R1 test mode off
        do_write(8'h06, 16'h0123, 6'b000001, 6'b000001, 6'b0); // R1 MSB high
        do_write(8'h06, 16'hFFFF, 6'b000001, 6'b0, 6'b0);  // R3 upper bits dropped
        do_write(8'h57, 16'hBEEF, 6'b100000, 6'b0, 6'b100000); // R2 MSB high
        do_write(8'h57, 16'hBEEF, 6'b100000, 6'b0, 6'b0);  // R4 shift
        do_write(8'h76, 16'h0555, 6'b101010, 6'b0, 6'b0);  // R6 partial broadcast
        do_write(8'h77, 16'h1234, 6'b111111, 6'b0, 6'b000100); // R6 broadcast w/ MSB
        do_write(8'h66, 16'h07FF, 6'b111111, 6'b0, 6'b0);  // R8 unused slot
        do_write(8'h67, 16'h07FF, 6'b111111, 6'b0, 6'b0);  // R8 unused slot
        do_write(8'h08, 16'h07FF, 6'b111111, 6'b0, 6'b0);  // R8 bad offset
        do_write(8'h36, 16'h0042, 6'b111111, 6'b0, 6'b0);  // R5 single channel

        // constrained random
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                a = 8'($urandom);
            end else begin
                a = {4'($urandom_range(0, 7)), 4'($urandom_range(6, 7))};
            end
            do_write(a, 16'($urandom), 6'($urandom), 6'($urandom & $urandom),
                     6'($urandom & $urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule